// File: doc/BRIEF.md
# Fast Blank Activity Monitor

This block watches one of two asynchronous fast blank lines and tells software whether an external RGB source is being inserted into the picture. A control bit picks the line to watch. The chosen line is brought into the system clock domain through a two-stage synchroniser. Two status bits are derived from it. The static bit follows the current level of the line. The dynamic bit is a sticky flag that a falling edge sets.

Software reads the two bits through a simple parallel register port. If the static bit is high and no edges are seen, the insertion covers the full screen. If edges keep setting the dynamic flag, the insertion is a box. Reading the status register clears the flag. Changing the selected line also clears it, so that the switch itself is never reported as activity.

Top module: `fb_monitor`

## Requirements
- R1: After reset, with both fast blank lines low, the control register (address 0) reads 0 and the status register (address 1) reads 0.
- R2: Bit 0 of the control register selects the monitored line: 0 selects fb_a_i and 1 selects fb_b_i. The full control byte reads back as it was written.
- R3: Status bit 0 (static) equals the selected line's level once two clock edges have passed since the line changed.
- R4: A falling edge on the selected line sets status bit 1 (dynamic). The bit stays set while the line stays low or rises again.
- R5: A read of the status register returns the current status and then clears the dynamic bit.
- R6: If a falling edge lands in the same cycle as a status read, that read returns the old dynamic value, and the dynamic bit stays set for the next read.
- R7: A write that changes the select bit clears the dynamic bit. The level difference between the old and new line is never reported as a falling edge.
- R8: Edges on the line that is not selected have no effect on the status.
- R9: Read data is registered: reg_rdata_o shows the addressed register one cycle after reg_re_i. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fb_a_i | input | 1 | Fast blank line A (asynchronous) |
| fb_b_i | input | 1 | Fast blank line B (asynchronous) |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Registered read data |

## Verification
The assertions assume that each read or write strobe lasts a single cycle, that reads and writes are never issued in the same cycle, and that the fast blank lines hold each level for several clock cycles so that the synchroniser passes every edge through. The bench changes the lines and the strobes only on the falling clock edge. It holds each line level for at least four cycles, except in the one case where it lines up an edge with a read on purpose, and it issues one access at a time.

// File: rtl/fb_monitor_pkg.sv
package fb_monitor_pkg;
  localparam int unsigned NUM_LINES = 2;
  localparam int unsigned SYNC_STAGES = 2;
  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_STAT = 2'd1
  } reg_addr_e;
  typedef struct packed {
    logic dyn;
    logic stat;
  } fb_status_t;
endpackage

// File: rtl/fb_sync.sv
module fb_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], async_i[i]};
    end
    assign sync_o[i] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/fb_edge_mon.sv
module fb_edge_mon
  import fb_monitor_pkg::*;
#(
  parameter int unsigned WIDTH = 2,
  localparam int unsigned SEL_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] line_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             sel_chg_i,
  input  logic             rd_clr_i,
  output fb_status_t       status_o
);
  logic cur, prev_q, skip_q, dyn_q, fall;

  assign cur  = line_i[sel_i];
  assign fall = prev_q & ~cur & ~skip_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      skip_q <= 1'b0;
      dyn_q  <= 1'b0;
    end else begin
      prev_q <= cur;
      skip_q <= sel_chg_i;  // mask first sample after mux switch
      if (sel_chg_i)     dyn_q <= 1'b0;
      else if (fall)     dyn_q <= 1'b1;
      else if (rd_clr_i) dyn_q <= 1'b0;
    end
  end

  assign status_o = '{dyn: dyn_q, stat: cur};

  assert_fall_sets_dyn_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall && !sel_chg_i) |=> dyn_q);
  assert_read_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !fall && !sel_chg_i) |=> !dyn_q);
  assert_sel_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_chg_i |=> !dyn_q);
  assert_no_switch_edge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_chg_i |=> ##1 !($rose(dyn_q)));
  assert_rise_needs_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dyn_q) |-> $past(prev_q) && !$past(cur));
endmodule

// File: rtl/fb_regs.sv
module fb_regs
  import fb_monitor_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  fb_status_t        status_i,
  output logic              sel_o,
  output logic              sel_chg_o,
  output logic              rd_clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] ctrl_q, rdata_q;
  logic hit_ctrl, hit_stat;

  assign hit_ctrl  = (addr_i == ADDR_W'(ADDR_CTRL));
  assign hit_stat  = (addr_i == ADDR_W'(ADDR_STAT));
  assign sel_o     = ctrl_q[0];
  assign sel_chg_o = we_i && hit_ctrl && (wdata_i[0] != ctrl_q[0]);
  assign rd_clr_o  = re_i && hit_stat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (we_i && hit_ctrl) ctrl_q <= wdata_i;
      if (re_i) begin
        if (hit_ctrl)      rdata_q <= ctrl_q;
        else if (hit_stat) rdata_q <= DATA_W'(status_i);
        else               rdata_q <= '0;
      end
    end
  end
  assign rdata_o = rdata_q;

  assert_ctrl_readback_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && hit_ctrl) |=> rdata_o == $past(ctrl_q));
  assert_stat_readback_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && hit_stat) |=> rdata_o[1:0] == $past(status_i));
  assert_rdata_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
endmodule

// File: rtl/fb_monitor.sv
module fb_monitor
  import fb_monitor_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fb_a_i,
  input  logic              fb_b_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o
);
  logic [NUM_LINES-1:0] line_sync;
  logic sel, sel_chg, rd_clr;
  fb_status_t status;

  fb_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .async_i({fb_b_i, fb_a_i}), .sync_o(line_sync)
  );

  fb_edge_mon #(.WIDTH(NUM_LINES)) u_edge (
    .clk_i, .rst_ni, .line_i(line_sync), .sel_i(sel),
    .sel_chg_i(sel_chg), .rd_clr_i(rd_clr), .status_o(status)
  );

  fb_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .re_i(reg_re_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .status_i(status), .sel_o(sel),
    .sel_chg_o(sel_chg), .rd_clr_o(rd_clr), .rdata_o(reg_rdata_o)
  );
endmodule

// File: tb/fb_monitor_bench.sv
module fb_monitor_bench;
  localparam int unsigned AW = 2;
  localparam int unsigned DW = 8;

  logic clk = 0, rst_n = 0;
  logic fb_a = 0, fb_b = 0, we = 0, re = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;

  int checks = 0, fails = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];
  logic pend = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fb_monitor #(.ADDR_W(AW), .DATA_W(DW)) u_fb_monitor (
    .clk_i(clk), .rst_ni(rst_n), .fb_a_i(fb_a), .fb_b_i(fb_b),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  // monitor: compare the read result one cycle after the strobe
  always @(posedge clk) pend <= re;
  always @(negedge clk) begin
    if (pend) begin
      logic [DW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        fails++;
        $display("FAIL %s: got %02h expected %02h", t, rdata, e);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [DW-1:0] e, string t);
    @(negedge clk); re = 1; addr = a; exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); re = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle(3); rst_n = 1; idle(2);
    rd(2'd0, 8'h00, "R1 ctrl reset");
    rd(2'd1, 8'h00, "R1 stat reset");
    rd(2'd2, 8'h00, "R9 unused addr");

    fb_a = 1; idle(4);
    rd(2'd1, 8'h01, "R3 static high on A");
    rd(2'd1, 8'h01, "R4 no edge, dyn clear");
    fb_a = 0; idle(4);
    rd(2'd1, 8'h02, "R4 fall sets dyn");
    rd(2'd1, 8'h00, "R5 read cleared dyn");

    fb_b = 1; idle(4); fb_b = 0; idle(4);
    rd(2'd1, 8'h00, "R8 unselected B edge ignored");

    fb_b = 1; idle(4);
    wr(2'd0, 8'hA5);
    rd(2'd0, 8'hA5, "R2 ctrl readback");
    rd(2'd1, 8'h01, "R2 B selected, static high");

    // switch from B(high) to A(low): must not look like a fall
    wr(2'd0, 8'h00); idle(3);
    rd(2'd1, 8'h00, "R7 no spurious edge on switch");

    // set dyn on A, then switch to B: dyn cleared
    fb_a = 1; idle(4); fb_a = 0; idle(4);
    wr(2'd0, 8'h01); idle(2);
    rd(2'd1, 8'h01, "R7 select change cleared dyn");

    // fall on B coincident with status read
    @(negedge clk); fb_b = 0;
    @(negedge clk);
    @(negedge clk); re = 1; addr = 2'd1; exp_q.push_back(8'h00); tag_q.push_back("R6 coincident read old value");
    @(negedge clk); re = 0;
    rd(2'd1, 8'h02, "R6 dyn survives coincident read");
    rd(2'd1, 8'h00, "R5 cleared after second read");

    // boxed insertion: repeated pulses, dyn set and static high
    for (int k = 0; k < 3; k++) begin
      fb_b = 1; idle(4); fb_b = 0; idle(4);
    end
    fb_b = 1; idle(4);
    rd(2'd1, 8'h03, "R4 boxed pulses, static and dyn");
    rd(2'd1, 8'h01, "R3 static remains after clear");

    idle(3);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule